// File: doc/BRIEF.md
# PWM Output Parity Monitor

This block watches a bus of pulse-width-modulated outputs, arranged as several timer slices with a fixed number of outputs each (4 slices of 4 outputs by default, 16 bits in all). Software chooses a subset of these bits with a mask, and the block reduces that subset to a single parity bit with an XOR tree. Once per PWM cycle, on a one-cycle sample strobe at the period boundary, it compares the parity bit with a reference signal. That reference is picked by a select field from a small set of external candidate inputs.

When a sample finds that the parity and the reference differ, the block raises a single-cycle interrupt request and sets an error status bit. The status bit is sticky: error-free PWM cycles that follow do not clear it. Only a software clear does, so an interrupt handler that serves several sources can still read the cause after later clean periods. If a clear and a new error arrive in the same cycle, the error wins.

Top module: `pwm_parity_checker`

## Requirements
- R1: While reset is held and directly after it, `err_status` and `err_irq` are both 0.
- R2: Bit index `s*OUTS_PER_SLICE + k` of `pwm_bus` is output k of slice s, and mask bit i enables bus bit i. The parity is the XOR of all bus bits whose mask bit is 1. On a cycle where `cycle_strobe` is 1 and this parity differs from the selected reference, `err_irq` is 1 and `err_status` is 1 in the following clock cycle.
- R3: A strobed sample whose parity equals the selected reference gives `err_irq` = 0 and leaves `err_status` unchanged.
- R4: `ref_sel` = n takes `ref_cand[n]` as the reference. A value of n that is not below `NUM_REFS` takes a constant 0.
- R5: `err_irq` is high for exactly one cycle per mismatching strobe. Strobes on consecutive cycles that both mismatch give two consecutive high cycles.
- R6: Once set, `err_status` stays 1 across later strobes that match and across cycles with no strobe, as long as `status_clr` is 0.
- R7: `status_clr` = 1 on a cycle with no mismatching strobe makes `err_status` 0 in the following cycle.
- R8: `status_clr` = 1 on the same cycle as a mismatching strobe leaves `err_status` at 1, and `err_irq` still pulses.
- R9: A cycle with `cycle_strobe` = 0 never causes `err_irq`, whatever the bus, mask and reference values.
- R10: An all-zero mask gives parity 0. A strobe then mismatches only when the reference is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| pwm_bus | input | NUM_SLICES*OUTS_PER_SLICE (16) | Monitored PWM outputs, slice-major order |
| sel_mask | input | NUM_SLICES*OUTS_PER_SLICE (16) | Per-bit enable into the XOR tree |
| ref_cand | input | NUM_REFS (4) | Candidate external reference inputs |
| ref_sel | input | clog2(NUM_REFS) (2) | Picks the reference from the candidates |
| cycle_strobe | input | 1 | One-cycle sample pulse at the PWM period boundary |
| status_clr | input | 1 | Software clear of the error status |
| err_status | output | 1 | Sticky mismatch status |
| err_irq | output | 1 | One-cycle interrupt request per mismatching sample |

## Verification
The assertions check the control rules on every cycle. The interrupt only follows a strobe, it always comes with the status set, the status holds until a clear, and a clear without a new error drops it. Whether the parity itself is right cannot be read from these outputs alone. The bench scenarios cover that: the masked parity of chosen bus patterns, including each single mask bit and the empty mask, and the routing of each reference candidate through the select field.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

  // XOR of the masked bits of one slice group
  function automatic logic masked_parity(input logic [31:0] bits,
                                         input logic [31:0] en,
                                         input int unsigned n);
    logic acc;
    acc = 1'b0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < n) acc = acc ^ (bits[i] & en[i]);
    end
    return acc;
  endfunction

endpackage

// File: rtl/pchk_xor_tree.sv
module pchk_xor_tree #(
  parameter int NUM_SLICES     = 4,
  parameter int OUTS_PER_SLICE = 4,
  localparam int BUS_W         = NUM_SLICES * OUTS_PER_SLICE
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [BUS_W-1:0] mask,
  output logic             parity
);
  import pchk_pkg::*;

  logic [NUM_SLICES-1:0] slice_par;

  // first level: one reduction per timer slice
  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    logic [31:0] bits_ext;
    logic [31:0] en_ext;
    always_comb begin
      bits_ext = '0;
      en_ext   = '0;
      bits_ext[OUTS_PER_SLICE-1:0] = bus[s*OUTS_PER_SLICE +: OUTS_PER_SLICE];
      en_ext[OUTS_PER_SLICE-1:0]   = mask[s*OUTS_PER_SLICE +: OUTS_PER_SLICE];
      slice_par[s] = masked_parity(bits_ext, en_ext, OUTS_PER_SLICE);
    end
  end

  // second level: combine slice results
  assign parity = ^slice_par;

endmodule

// File: rtl/pchk_ref_mux.sv
module pchk_ref_mux #(
  parameter int NUM_REFS = 4,
  localparam int SEL_W   = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
  input  logic [NUM_REFS-1:0] cand,
  input  logic [SEL_W-1:0]    sel,
  output logic                ref_bit
);

  always_comb begin
    ref_bit = 1'b0;
    for (int i = 0; i < NUM_REFS; i++) begin
      if (sel == SEL_W'(i)) ref_bit = cand[i];
    end
  end

endmodule

// File: rtl/pchk_status.sv
module pchk_status (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic parity,
  input  logic ref_bit,
  input  logic clr,
  output logic status,
  output logic irq
);

  logic mismatch;
  logic status_q, status_d, status_en;
  logic irq_q, irq_d;

  // next-state logic
  always_comb begin
    mismatch  = strobe & (parity ^ ref_bit);
    status_en = mismatch | clr;
    status_d  = mismatch ? 1'b1 : 1'b0;
    irq_d     = mismatch;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (status_en) status_q <= status_d;
      irq_q <= irq_d;
    end
  end

  assign status = status_q;
  assign irq    = irq_q;

endmodule

// File: rtl/pwm_parity_checker.sv
module pwm_parity_checker #(
  parameter int NUM_SLICES     = 4,
  parameter int OUTS_PER_SLICE = 4,
  parameter int NUM_REFS       = 4,
  localparam int BUS_W         = NUM_SLICES * OUTS_PER_SLICE,
  localparam int SEL_W         = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BUS_W-1:0]    pwm_bus,
  input  logic [BUS_W-1:0]    sel_mask,
  input  logic [NUM_REFS-1:0] ref_cand,
  input  logic [SEL_W-1:0]    ref_sel,
  input  logic                cycle_strobe,
  input  logic                status_clr,
  output logic                err_status,
  output logic                err_irq
);

  logic parity;
  logic ref_bit;

  pchk_xor_tree #(
    .NUM_SLICES    (NUM_SLICES),
    .OUTS_PER_SLICE(OUTS_PER_SLICE)
  ) u_tree (
    .bus   (pwm_bus),
    .mask  (sel_mask),
    .parity(parity)
  );

  pchk_ref_mux #(
    .NUM_REFS(NUM_REFS)
  ) u_mux (
    .cand   (ref_cand),
    .sel    (ref_sel),
    .ref_bit(ref_bit)
  );

  pchk_status u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cycle_strobe),
    .parity (parity),
    .ref_bit(ref_bit),
    .clr    (status_clr),
    .status (err_status),
    .irq    (err_irq)
  );

endmodule

// File: rtl/pwm_parity_checker_sva.sv
module pwm_parity_checker_sva (
  input logic clk,
  input logic rst_n,
  input logic cycle_strobe,
  input logic status_clr,
  input logic err_status,
  input logic err_irq
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_irq_sets_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> err_status);

  assert_irq_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(cycle_strobe)) |-> !err_irq);

  assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(err_status) && !$past(status_clr)) |-> err_status);

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(status_clr) && !err_irq) |-> !err_status);

  assert_error_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(status_clr) && err_irq) |-> err_status);

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!err_irq);
    end
  end

endmodule

bind pwm_parity_checker pwm_parity_checker_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .cycle_strobe(cycle_strobe),
  .status_clr  (status_clr),
  .err_status  (err_status),
  .err_irq     (err_irq)
);

// File: tb/pwm_parity_checker_test.sv
module pwm_parity_checker_test;

  localparam int BW = 16;
  localparam int NR = 4;

  logic          clk;
  logic          rst_n;
  logic [BW-1:0] pwm_bus, sel_mask;
  logic [NR-1:0] ref_cand;
  logic [1:0]    ref_sel;
  logic          cycle_strobe, status_clr;
  logic          err_status, err_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic model_status = 1'b0;

  typedef struct {
    logic  irq;
    logic  status;
    string tag;
  } exp_t;
  exp_t sb[$];

  pwm_parity_checker uut (
    .clk(clk), .rst_n(rst_n), .pwm_bus(pwm_bus), .sel_mask(sel_mask),
    .ref_cand(ref_cand), .ref_sel(ref_sel), .cycle_strobe(cycle_strobe),
    .status_clr(status_clr), .err_status(err_status), .err_irq(err_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected outputs
  task automatic drive(input logic [BW-1:0] pwm, input logic [BW-1:0] mask,
                       input logic [NR-1:0] cand, input logic [1:0] sel,
                       input logic strb, input logic clr, input string tag);
    logic par, mm;
    exp_t e;
    @(negedge clk);
    pwm_bus = pwm; sel_mask = mask; ref_cand = cand; ref_sel = sel;
    cycle_strobe = strb; status_clr = clr;
    par = 1'b0;
    for (int i = 0; i < BW; i++) par ^= pwm[i] & mask[i];
    mm = strb && (par != cand[sel]);
    if (mm) model_status = 1'b1;
    else if (clr) model_status = 1'b0;
    e.irq = mm; e.status = model_status; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive('0, '0, '0, 2'd0, 1'b0, 1'b0, tag);
  endtask

  // monitor: compare just after the edge that captured the stimulus
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(err_irq,    e.irq,    {e.tag, " irq"});
        check(err_status, e.status, {e.tag, " status"});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pwm_bus = '0; sel_mask = '0; ref_cand = '0; ref_sel = '0;
    cycle_strobe = 1'b0; status_clr = 1'b0;
    repeat (3) @(negedge clk);
    check(err_irq, 1'b0, "R1 reset irq");
    check(err_status, 1'b0, "R1 reset status");
    rst_n = 1'b1;
    idle("R1 after reset");

    // R3: odd parity of full mask matches reference 1
    drive(16'h0007, 16'hFFFF, 4'b0001, 2'd0, 1'b1, 1'b0, "R3 match");
    // R2: same data, reference 0 mismatches
    drive(16'h0007, 16'hFFFF, 4'b0000, 2'd0, 1'b1, 1'b0, "R2 mismatch");
    idle("R5 pulse ends");
    // R6: later matching strobe and idle cycles keep status
    drive(16'h00F0, 16'h00FF, 4'b0000, 2'd0, 1'b1, 1'b0, "R6 clean strobe");
    idle("R6 idle");
    // R7: clear
    drive('0, '0, '0, 2'd0, 1'b0, 1'b1, "R7 clear");
    idle("R7 after clear");

    // R4: each candidate through the select
    for (int k = 0; k < NR; k++) begin
      drive(16'h0000, 16'hFFFF, NR'(1 << k), 2'(k), 1'b1, 1'b1, "R4 select mismatch");
      drive(16'h0001, 16'hFFFF, ~NR'(1 << k), 2'(k), 1'b1, 1'b1, "R4 select other candidates");
    end
    drive('0, '0, '0, 2'd0, 1'b0, 1'b1, "R7 clear");

    // R9: mismatching data without strobe
    drive(16'h0001, 16'hFFFF, 4'b0000, 2'd0, 1'b0, 1'b0, "R9 no strobe");
    idle("R9 idle");

    // R10: empty mask
    drive(16'hFFFF, 16'h0000, 4'b0000, 2'd0, 1'b1, 1'b0, "R10 empty mask ref0");
    drive(16'hFFFF, 16'h0000, 4'b0001, 2'd0, 1'b1, 1'b0, "R10 empty mask ref1");

    // R8: clear with simultaneous error
    drive(16'h0003, 16'h0001, 4'b0000, 2'd0, 1'b1, 1'b1, "R8 clear and error");
    drive('0, '0, '0, 2'd0, 1'b0, 1'b1, "R7 clear");

    // R5: back-to-back mismatching strobes
    drive(16'h0100, 16'h0100, 4'b0000, 2'd0, 1'b1, 1'b0, "R5 first");
    drive(16'h0100, 16'h0100, 4'b0000, 2'd0, 1'b1, 1'b0, "R5 second");
    idle("R5 tail");

    // R2: each mask bit position on its own
    for (int i = 0; i < BW; i++) begin
      drive('0, '0, '0, 2'd0, 1'b0, 1'b1, "R7 clear");
      drive(BW'(1) << i, BW'(1) << i, 4'b0000, 2'd0, 1'b1, 1'b0, "R2 single bit");
      drive(BW'(1) << i, ~(BW'(1) << i), 4'b0000, 2'd0, 1'b1, 1'b0, "R2 bit masked off");
    end
    idle("final");
    idle("final");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule